// File: doc/BRIEF.md
# Audio Time-Shift Buffer Controller

This block lets a listener pause, rewind and replay a live audio stream. Incoming 12-bit samples, each flagged by a valid strobe, are written without interruption into a circular single-port RAM that sits outside the block. The block also keeps a playback position that lags the newest stored sample by a variable distance. It reads that position once per sample period and sends the word it reads to a 12-bit output stream. The default depth of 30,000,000 words holds ten minutes of history at 50,000 samples per second.

Debounced button levels steer the playback position. The block acts on the rising edge of the play/pause, live and begin buttons. The rewind button is timed in sample strobes. A short press moves playback back by a fixed jump when the button is released. A longer hold plays the stored audio backwards at the sample rate. No move can take playback to a sample that has already been overwritten, or to one that has not yet arrived. Three LEDs show power, pause and live-tracking.

Top module: `tshift_ctrl`

## Requirements
- R1: In every cycle with `smp_in_vld` high, the block drives `ram_we` high, `ram_wdata` equal to `smp_in`, and `ram_addr` equal to the count of earlier strobes modulo DEPTH. No other cycle writes.
- R2: Strobes are at least 2 cycles apart. When a strobe in cycle S finds the block playing or reversing, `smp_out_vld` is high for cycle S+3 only. When the block is paused, `smp_out_vld` stays low. The read takes place in cycle S+1 and the RAM returns data one cycle after the address.
- R3: A rising edge on `btn_play` toggles pause. Writing continues while paused. When play resumes, output continues from the sample that follows the last one played.
- R4: The rewind button held through fewer than HOLD strobes and then released moves playback back by JUMP samples, applied in the release cycle and clamped at the oldest stored sample. A hold through HOLD or more strobes never causes a jump.
- R5: While the rewind button is held and has already counted HOLD strobes, each strobe moves playback back by one sample and outputs that sample, and pause is cleared. After release, forward play continues from that point.
- R6: A rising edge on `btn_live` moves playback to the newest stored sample and clears pause.
- R7: A rising edge on `btn_begin` moves playback to the oldest stored sample.
- R8: The history holds at most DEPTH samples. Playback never points at a sample older than that. If a pause outlasts the history, playback is pushed forward so that it stays on the oldest sample.
- R9: `led_power` is always 1. `led_pause` is 1 exactly while paused. `led_live` is 1 exactly while not paused and playback sits on the newest stored sample.
- R10: When a strobe and a command fall in the same cycle, the strobe's own move (forward, hold or back) is applied first and the command second. Among commands, live wins over begin, and begin wins over a rewind jump.
- R11: After reset the history is empty, the block is not paused, and it is in live mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_in | input | SW | Incoming audio sample |
| smp_in_vld | input | 1 | Sample strobe, one cycle per sample |
| btn_rew | input | 1 | Debounced rewind button level |
| btn_play | input | 1 | Debounced play/pause button level |
| btn_live | input | 1 | Debounced jump-to-live button level |
| btn_begin | input | 1 | Debounced jump-to-oldest button level |
| smp_out | output | SW | Played-back sample |
| smp_out_vld | output | 1 | Played-back sample valid |
| ram_addr | output | AW | RAM word address |
| ram_wdata | output | SW | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | SW | RAM read data, one cycle after address |
| led_power | output | 1 | Power indicator |
| led_pause | output | 1 | Pause indicator |
| led_live | output | 1 | Live-tracking indicator |

## Verification
A sample strobe and a button edge can land in the same cycle. The strobe advances the writer and the lag, and the command then resets or jumps the playback position. A rewind release can also coincide with a strobe. The bench places begin, live-plus-begin, play and rewind-release edges exactly on strobe cycles. A queue-based model is updated in the order R10 prescribes, so any misordering shows up as a wrong played-back sample three cycles later or as a wrong LED state.

// File: rtl/tshift_pkg.sv
package tshift_pkg;

  // Clamp a requested lag so playback never passes the oldest stored word.
  function automatic logic [31:0] clamp_back(input logic [31:0] want,
                                             input logic [31:0] filled);
    if (filled == 32'd0)          return 32'd0;
    else if (want > filled - 1)   return filled - 1;
    else                          return want;
  endfunction

  // Physical address of the word 'lag' samples behind the newest one.
  function automatic logic [31:0] read_addr(input logic [31:0] wptr,
                                            input logic [31:0] lag,
                                            input logic [31:0] depth);
    logic [31:0] newest;
    newest = (wptr == 32'd0) ? depth - 1 : wptr - 1;
    return (newest >= lag) ? newest - lag : newest + depth - lag;
  endfunction

endpackage

// File: rtl/tshift_rew_timer.sv
module tshift_rew_timer #(
  parameter int HOLD = 150_000,
  parameter int HW   = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic btn,
  output logic jump,
  output logic reverse
);
  localparam logic [HW-1:0] HOLD_C = HW'(HOLD);

  logic          btn_q;
  logic [HW-1:0] cnt;
  logic          at_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btn_q <= 1'b0;
      cnt   <= '0;
    end else begin
      btn_q <= btn;
      if (!btn)                      cnt <= '0;
      else if (stb && !at_hold)      cnt <= cnt + HW'(1);
    end
  end

  assign at_hold = (cnt == HOLD_C);
  assign reverse = btn && at_hold;
  assign jump    = btn_q && !btn && !at_hold;

  // R4: a jump leaves the hold counter cleared
  a_r4_jump_clears: assert property (@(posedge clk) disable iff (!rst_n)
    jump |=> (cnt == '0));
  // R5: reverse stays on as long as the button stays held
  a_r5_rev_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (reverse && btn) |=> (reverse || !btn));

endmodule

// File: rtl/tshift_ptr.sv
module tshift_ptr
  import tshift_pkg::*;
#(
  parameter int DEPTH = 30_000_000,
  parameter int JUMP  = 750_000,
  parameter int AW    = 25,
  parameter int CW    = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          reverse,
  input  logic          jump,
  input  logic          btn_play,
  input  logic          btn_live,
  input  logic          btn_begin,
  output logic [AW-1:0] wptr,
  output logic [CW-1:0] lag,
  output logic          paused,
  output logic          out_en,
  output logic          live
);
  logic          play_q, live_q, begin_q;
  logic          play_e, live_e, begin_e;
  logic [CW-1:0] fill;
  logic [31:0]   f32, fn32, base, want, lag_n;
  logic          paused_n;

  assign play_e  = btn_play  && !play_q;
  assign live_e  = btn_live  && !live_q;
  assign begin_e = btn_begin && !begin_q;

  always_comb begin
    f32  = 32'(fill);
    fn32 = (stb && f32 != 32'(DEPTH)) ? f32 + 32'd1 : f32;
    base = 32'(lag);
    if (stb) begin
      if (reverse)     base = 32'(lag) + 32'd2;
      else if (paused) base = 32'(lag) + 32'd1;
    end
    if (live_e)       want = 32'd0;
    else if (begin_e) want = (fn32 == 32'd0) ? 32'd0 : fn32 - 32'd1;
    else if (jump)    want = base + 32'(JUMP);
    else              want = base;
    lag_n = clamp_back(want, fn32);
    if (live_e || reverse) paused_n = 1'b0;
    else if (play_e)       paused_n = !paused;
    else                   paused_n = paused;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      play_q  <= 1'b0;
      live_q  <= 1'b0;
      begin_q <= 1'b0;
      fill    <= '0;
      lag     <= '0;
      wptr    <= '0;
      paused  <= 1'b0;
    end else begin
      play_q  <= btn_play;
      live_q  <= btn_live;
      begin_q <= btn_begin;
      fill    <= CW'(fn32);
      lag     <= CW'(lag_n);
      paused  <= paused_n;
      if (stb) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
    end
  end

  assign out_en = !paused || reverse;
  assign live   = (lag == '0) && !paused;

  // R8: history never exceeds the buffer depth
  a_r8_fill_cap: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fill) <= 32'(DEPTH));
  // R8: playback stays inside stored history
  a_r8_lag_in_history: assert property (@(posedge clk) disable iff (!rst_n)
    (fill != '0) |-> (lag < fill));
  // R6: a live edge lands on the newest sample, unpaused
  a_r6_live_lands: assert property (@(posedge clk) disable iff (!rst_n)
    live_e |=> (lag == '0 && !paused));
  // R3: a lone play edge flips the pause state
  a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (play_e && !live_e && !reverse) |=> (paused != $past(paused)));

endmodule

// File: rtl/tshift_ramseq.sv
module tshift_ramseq
  import tshift_pkg::*;
#(
  parameter int SW    = 12,
  parameter int DEPTH = 30_000_000,
  parameter int AW    = 25,
  parameter int CW    = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic [SW-1:0] smp_in,
  input  logic          out_en,
  input  logic [AW-1:0] wptr,
  input  logic [CW-1:0] lag,
  output logic [AW-1:0] ram_addr,
  output logic [SW-1:0] ram_wdata,
  output logic          ram_we,
  input  logic [SW-1:0] ram_rdata,
  output logic [SW-1:0] smp_out,
  output logic          smp_out_vld
);
  logic          rd_go, rd_pend;
  logic [AW-1:0] rd_addr;

  assign rd_addr   = AW'(read_addr(32'(wptr), 32'(lag), 32'(DEPTH)));
  assign ram_we    = stb;
  assign ram_wdata = smp_in;
  assign ram_addr  = stb ? wptr : rd_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_go       <= 1'b0;
      rd_pend     <= 1'b0;
      smp_out     <= '0;
      smp_out_vld <= 1'b0;
    end else begin
      rd_go       <= stb && out_en;
      rd_pend     <= rd_go;
      smp_out_vld <= rd_pend;
      if (rd_pend) smp_out <= ram_rdata;
    end
  end

  // R2: an output strobe is always two cycles behind a read slot
  a_r2_vld_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    smp_out_vld |-> $past(rd_go, 2));
  // R2: a read slot never collides with a write
  a_r2_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |-> !ram_we);
  // R1: a strobe writes at the writer position
  a_r1_write_at_wptr: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> (ram_we && ram_addr == wptr));

endmodule

// File: rtl/tshift_ctrl.sv
module tshift_ctrl #(
  parameter int SW    = 12,
  parameter int DEPTH = 30_000_000,
  parameter int JUMP  = 750_000,
  parameter int HOLD  = 150_000,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int HW   = $clog2(HOLD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] smp_in,
  input  logic          smp_in_vld,
  input  logic          btn_rew,
  input  logic          btn_play,
  input  logic          btn_live,
  input  logic          btn_begin,
  output logic [SW-1:0] smp_out,
  output logic          smp_out_vld,
  output logic [AW-1:0] ram_addr,
  output logic [SW-1:0] ram_wdata,
  output logic          ram_we,
  input  logic [SW-1:0] ram_rdata,
  output logic          led_power,
  output logic          led_pause,
  output logic          led_live
);
  logic          jump, reverse, paused, out_en, live;
  logic [AW-1:0] wptr;
  logic [CW-1:0] lag;

  tshift_rew_timer #(.HOLD(HOLD), .HW(HW)) u_timer (
    .clk(clk), .rst_n(rst_n), .stb(smp_in_vld), .btn(btn_rew),
    .jump(jump), .reverse(reverse)
  );

  tshift_ptr #(.DEPTH(DEPTH), .JUMP(JUMP), .AW(AW), .CW(CW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .stb(smp_in_vld), .reverse(reverse),
    .jump(jump), .btn_play(btn_play), .btn_live(btn_live),
    .btn_begin(btn_begin), .wptr(wptr), .lag(lag), .paused(paused),
    .out_en(out_en), .live(live)
  );

  tshift_ramseq #(.SW(SW), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .stb(smp_in_vld), .smp_in(smp_in),
    .out_en(out_en), .wptr(wptr), .lag(lag), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_rdata(ram_rdata),
    .smp_out(smp_out), .smp_out_vld(smp_out_vld)
  );

  assign led_power = 1'b1;
  assign led_pause = paused;
  assign led_live  = live;

  // R9: live and pause indicators are never lit together
  a_r9_led_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(led_live && led_pause));

endmodule

// File: tb/tshift_ctrl_tb.sv
`timescale 1ns/1ps
module tshift_ctrl_tb;
  localparam int SW = 12, DEPTH = 40, JUMP = 6, HOLD = 5;
  localparam int AW = $clog2(DEPTH);

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [SW-1:0] smp_in = '0;
  logic          smp_in_vld = 1'b0;
  logic          btn_rew = 1'b0, btn_play = 1'b0, btn_live = 1'b0, btn_begin = 1'b0;
  logic [SW-1:0] smp_out, ram_wdata, ram_rdata;
  logic          smp_out_vld, ram_we, led_power, led_pause, led_live;
  logic [AW-1:0] ram_addr;

  always #2.5 clk = ~clk;

  tshift_ctrl #(.SW(SW), .DEPTH(DEPTH), .JUMP(JUMP), .HOLD(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .smp_in_vld(smp_in_vld),
    .btn_rew(btn_rew), .btn_play(btn_play), .btn_live(btn_live),
    .btn_begin(btn_begin), .smp_out(smp_out), .smp_out_vld(smp_out_vld),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
    .ram_rdata(ram_rdata), .led_power(led_power), .led_pause(led_pause),
    .led_live(led_live)
  );

  // RAM with one-cycle read latency
  logic [SW-1:0] mem [0:(1<<AW)-1];
  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    ram_rdata <= mem[ram_addr];
  end

  // Reference model: absolute sample indices into a history queue
  int hist[$];
  int n, r, hcnt, oldest;
  bit m_paused, q_rew, q_play, q_live, q_begin;
  bit rev, jmp, oe, pe, le, be;
  bit pv0, pv1, pv2;
  int pd0, pd1, pd2;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      n = 0; r = -1; hcnt = 0; m_paused = 0;
      q_rew = 0; q_play = 0; q_live = 0; q_begin = 0;
      pv0 = 0; pv1 = 0; pv2 = 0; pd0 = 0; pd1 = 0; pd2 = 0;
    end else begin
      rev = btn_rew && hcnt >= HOLD;
      jmp = q_rew && !btn_rew && hcnt < HOLD;
      oe  = !m_paused || rev;
      pe  = btn_play && !q_play;
      le  = btn_live && !q_live;
      be  = btn_begin && !q_begin;
      if (smp_in_vld) begin
        hist.push_back(int'(smp_in));
        n++;
        if (rev) r--;
        else if (!m_paused) r++;
      end
      oldest = (n > DEPTH) ? n - DEPTH : 0;
      if (le)       r = n - 1;
      else if (be)  r = (n == 0) ? -1 : oldest;
      else if (jmp) r = r - JUMP;
      if (n > 0 && r < oldest) r = oldest;
      if (le || rev) m_paused = 0;
      else if (pe)   m_paused = !m_paused;
      if (!btn_rew) hcnt = 0;
      else if (smp_in_vld && hcnt < HOLD) hcnt++;
      pv2 = pv1; pd2 = pd1; pv1 = pv0; pd1 = pd0;
      pv0 = smp_in_vld && oe;
      pd0 = pv0 ? hist[r] : 0;
      q_rew = btn_rew; q_play = btn_play; q_live = btn_live; q_begin = btn_begin;
    end
  end

  int vecs = 0, bad = 0;
  string tag = "R11";
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9", int'(led_power), 1);
      chk("R9", int'(led_pause), int'(m_paused));
      chk("R9", int'(led_live), int'(!m_paused && r == n - 1));
      chk("R1", int'(ram_we), int'(smp_in_vld));
      if (smp_in_vld) begin
        chk("R1", int'(ram_addr), n % DEPTH);
        chk("R1", int'(ram_wdata), int'(smp_in));
      end
      chk("R2", int'(smp_out_vld), int'(pv2));
      if (pv2) chk(tag, int'(smp_out), pd2);
    end
  end

  int seq = 0;
  task automatic step(input bit v, input bit pl, input bit lv, input bit bg, input bit rw);
    @(posedge clk); #1;
    smp_in_vld = v;
    if (v) begin seq++; smp_in = SW'((seq * 37 + 5) & 12'hfff); end
    btn_play = pl; btn_live = lv; btn_begin = bg; btn_rew = rw;
  endtask

  task automatic strobes(input int k, input bit rw);
    for (int i = 0; i < k; i++) begin
      step(1, 0, 0, 0, rw);
      step(0, 0, 0, 0, rw); step(0, 0, 0, 0, rw); step(0, 0, 0, 0, rw);
    end
  endtask

  task automatic press(input bit pl, input bit lv, input bit bg);
    step(0, pl, lv, bg, 0); step(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      vecs++; bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state is live, unpaused, silent
    chk("R11", int'(led_live), 1);
    chk("R11", int'(led_pause), 0);
    chk("R11", int'(smp_out_vld), 0);
    tag = "R1"; strobes(12, 0);
    // R3 and R8: pause long enough to overrun the history
    tag = "R3"; press(1, 0, 0);
    tag = "R8"; strobes(55, 0);
    tag = "R3"; press(1, 0, 0); strobes(8, 0);
    // R4: short press jumps back on release; exact-HOLD press does not
    tag = "R4"; strobes(2, 1); strobes(8, 0);
    strobes(HOLD, 1); strobes(6, 0);
    // R5: long hold reverses, also from pause
    tag = "R5"; strobes(HOLD + 10, 1); strobes(6, 0);
    press(1, 0, 0); strobes(3, 0); strobes(HOLD + 4, 1); strobes(5, 0);
    // R7: jump to oldest, then R4 clamp at oldest
    tag = "R7"; press(0, 0, 1); strobes(5, 0);
    tag = "R4"; strobes(1, 1); strobes(5, 0);
    // R6: back to live
    tag = "R6"; press(0, 1, 0); strobes(5, 0);
    // R10: commands landing on strobe cycles
    tag = "R10";
    step(1, 0, 0, 1, 0); step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    strobes(3, 0);
    step(1, 0, 1, 1, 0); step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    strobes(3, 0);
    strobes(2, 1);
    step(1, 0, 0, 0, 0); step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    strobes(3, 0);
    step(1, 1, 0, 0, 0); step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    strobes(4, 0);
    step(1, 1, 0, 0, 0); step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    strobes(4, 0);
    repeat (6) step(0, 0, 0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule